// File: doc/BRIEF.md
# Oversampled Serial Word Receiver

This block turns an asynchronous, idle-high serial line into parallel words. It is driven by the system clock and qualified by a one-cycle enable pulse that arrives at sixteen times the bit rate. The line first passes through a short flip-flop synchronizer. While the receiver is idle, the first enable pulse that finds the synchronized line low starts a frame. The timing of every later bit is counted from that pulse.

Data bits are sampled halfway through their windows and collected, least significant bit first, in an internal shift register. Once the stop-bit window has run out, the assembled word is copied into an output holding register and a level ready flag is raised. The host reads the word and pulses an acknowledge input to drop the flag. The block checks neither parity nor framing and keeps no record of overruns. A word that completes before the previous one is acknowledged replaces it.

Top module: `serial_word_receiver`

## Requirements
- R1: While idle, reception starts on the first enable pulse that finds the synchronized line at 0. A line held at 1 never starts a frame and never raises the ready flag.
- R2: After the start is detected, exactly 16 enable pulses pass (the start-bit window) before the first data-bit window opens.
- R3: Each data bit occupies 16 enable pulses and is sampled on the 8th pulse of its window. Bits arrive least significant first, so `wordOut[i]` is the i-th data bit after the start bit.
- R4: The receiver advances only on cycles where `tickEn` is 1. A frame is decoded correctly when the enable pulses are spaced several clocks apart.
- R5: `wordOut` and `wordReady` change only after the 16-pulse stop window ends. During a later frame, `wordOut` keeps the previously delivered word.
- R6: The value of the line during the stop window is ignored. A frame whose stop bit is held at 0 still delivers its word.
- R7: A one-cycle `readAck` clears `wordReady` on the next clock edge and leaves `wordOut` unchanged.
- R8: If a new word completes while `wordReady` is still 1, it silently replaces `wordOut` and `wordReady` stays 1.
- R9: After reset, `wordReady` is 0 and `wordOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle enable pulse at 16 times the bit rate |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| readAck | input | 1 | Host acknowledge; clears the ready flag |
| wordOut | output | 8 | Last completed word |
| wordReady | output | 1 | High while an unacknowledged word is held |

## Verification
All 256 byte values are sent with an enable pulse on every clock and acknowledged one by one. This sweep separates a correct bit order and sampling point from a reversed or shifted assembly, and from a start window of the wrong length. A few words are then sent with enable pulses three clocks apart, which exposes any logic that counts clocks instead of pulses. Further patterns cover the remaining cases:
- a frame with a low stop bit, which shows the stop value is ignored;
- two frames with no acknowledge between them, which shows the replacement;
- a check of the output in the middle of a frame, which shows it is not updated early;
- a long idle-high stretch, which must produce no word.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic sampleBit;
    logic loadBuf;
  } rxStrobe_t;

endpackage

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
  import rxw_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      rxSync,
  output rxStrobe_t strobes
);

  localparam int TCW = $clog2(OVERSAMPLE);
  localparam int BCW = $clog2(DATA_BITS + 1);
  localparam logic [TCW-1:0] LAST_TICK = TCW'(OVERSAMPLE - 1);
  localparam logic [TCW-1:0] MID_TICK  = TCW'(OVERSAMPLE / 2 - 1);
  localparam logic [BCW-1:0] LAST_BIT  = BCW'(DATA_BITS - 1);

  rxState_t       state;
  logic [TCW-1:0] tickCnt;
  logic [BCW-1:0] bitCnt;
  logic           windowEnd;

  assign windowEnd = (tickCnt == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (tickEn) begin
      case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          bitCnt  <= '0;
          if (!rxSync) state <= RX_START;
        end
        RX_START: begin
          if (windowEnd) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= RX_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (windowEnd) begin
            tickCnt <= '0;
            if (bitCnt == LAST_BIT) state <= RX_STOP;
            else                    bitCnt <= bitCnt + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (windowEnd) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.sampleBit = tickEn && (state == RX_DATA) && (tickCnt == MID_TICK);
    strobes.loadBuf   = tickEn && (state == RX_STOP) && windowEnd;
  end

  // R1: an idle receiver that sees a low line on a pulse enters the start window
  p_idle_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE && tickEn && !rxSync) |=> (state == RX_START));

  // R4: without an enable pulse the counters and state hold
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(tickCnt) && $stable(state) && $stable(bitCnt)));

  // R3: the bit index never passes the last data bit
  p_bit_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);

  // R2: the start window always hands over to the data windows
  p_start_to_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && tickEn && windowEnd) |=> (state == RX_DATA && bitCnt == '0));

endmodule

// File: rtl/rxw_datapath.sv
module rxw_datapath
  import rxw_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  logic                 readAck,
  input  rxStrobe_t            strobes,
  output logic                 rxSync,
  output logic [DATA_BITS-1:0] wordOut,
  output logic                 wordReady
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DATA_BITS-1:0]   shiftReg;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= serialIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b1;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign rxSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  shiftReg <= '0;
    else if (strobes.sampleBit) shiftReg <= {rxSync, shiftReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordReady <= 1'b0;
    end else if (strobes.loadBuf) begin
      wordOut   <= shiftReg;
      wordReady <= 1'b1;
    end else if (readAck) begin
      wordReady <= 1'b0;
    end
  end

  // R5: the output word only moves on a buffer load
  p_buf_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadBuf |=> $stable(wordOut));

  // R7: an acknowledge with no competing load drops the flag
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (readAck && !strobes.loadBuf) |=> !wordReady);

  // R8: a load always leaves the flag raised, acknowledged or not
  p_load_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBuf |=> wordReady);

  // R5: the flag rises only as a result of a load
  p_ready_origin_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wordReady && !strobes.loadBuf) |=> !wordReady);

endmodule

// File: rtl/serial_word_receiver.sv
module serial_word_receiver
  import rxw_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 serialIn,
  input  logic                 readAck,
  output logic [DATA_BITS-1:0] wordOut,
  output logic                 wordReady
);

  rxStrobe_t strobes;
  logic      rxSync;

  rxw_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .rxSync (rxSync),
    .strobes(strobes)
  );

  rxw_datapath #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .readAck  (readAck),
    .strobes  (strobes),
    .rxSync   (rxSync),
    .wordOut  (wordOut),
    .wordReady(wordReady)
  );

  // R6: loads and samples never coincide, so the stop window contributes no bit
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadBuf && strobes.sampleBit));

endmodule

// File: tb/sim_serial_word_receiver.sv
module sim_serial_word_receiver;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       serialIn = 1'b1;
  logic       readAck = 1'b0;
  logic [7:0] wordOut;
  logic       wordReady;

  int checks = 0;
  int fails  = 0;
  int tickDiv = 1;
  int divCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_word_receiver u0 (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .serialIn (serialIn),
    .readAck  (readAck),
    .wordOut  (wordOut),
    .wordReady(wordReady)
  );

  always @(negedge clk) begin
    tickEn <= (divCnt == 0);
    divCnt <= (divCnt + 1 >= tickDiv) ? 0 : divCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic holdTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tickEn) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [7:0] w, input bit stopLow);
    serialIn = 1'b0;
    holdTicks(16);
    for (int i = 0; i < 8; i++) begin
      serialIn = w[i];
      holdTicks(16);
    end
    if (stopLow) begin
      serialIn = 1'b0;
      holdTicks(12);
      serialIn = 1'b1;
      holdTicks(4);
    end else begin
      serialIn = 1'b1;
      holdTicks(16);
    end
    holdTicks(6);
  endtask

  task automatic ackWord();
    readAck = 1'b1;
    @(negedge clk);
    readAck = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(wordReady == 1'b0, "R9 ready", wordReady, 0);
    check(wordOut == 8'h00, "R9 word", wordOut, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: idle high line never yields a word
    holdTicks(200);
    check(wordReady == 1'b0, "R1 idle", wordReady, 0);

    // R2 R3: full sweep, enable every clock, LSB first
    for (int v = 0; v < 256; v++) begin
      sendWord(v[7:0], 1'b0);
      check(wordReady == 1'b1, "R2 ready", wordReady, 1);
      check(wordOut == v[7:0], "R3 word", wordOut, v);
      held = wordOut;
      ackWord();
      // R7: acknowledge clears flag, keeps word
      check(wordReady == 1'b0, "R7 clear", wordReady, 0);
      check(wordOut == held, "R7 keep", wordOut, held);
    end

    // R4: enable pulses three clocks apart
    tickDiv = 3;
    holdTicks(4);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] pat;
      pat = 8'(8'h3A * k + 8'h81);
      sendWord(pat, 1'b0);
      check(wordReady == 1'b1 && wordOut == pat, "R4 slow tick", wordOut, pat);
      ackWord();
    end
    tickDiv = 1;
    holdTicks(4);

    // R6: low stop bit still delivers
    sendWord(8'hC5, 1'b1);
    check(wordReady == 1'b1 && wordOut == 8'hC5, "R6 low stop", wordOut, 8'hC5);
    ackWord();
    holdTicks(20);
    check(wordReady == 1'b0, "R6 no extra frame", wordReady, 0);

    // R5: word holds during a later frame
    sendWord(8'h5E, 1'b0);
    ackWord();
    fork
      sendWord(8'hA7, 1'b0);
      begin
        holdTicks(80);
        check(wordOut == 8'h5E, "R5 mid-frame word", wordOut, 8'h5E);
        check(wordReady == 1'b0, "R5 mid-frame ready", wordReady, 0);
        holdTicks(70);
        check(wordOut == 8'h5E, "R5 stop window", wordOut, 8'h5E);
      end
    join
    check(wordOut == 8'hA7, "R5 after stop", wordOut, 8'hA7);

    // R8: second word without acknowledge overwrites
    sendWord(8'h19, 1'b0);
    check(wordReady == 1'b1 && wordOut == 8'h19, "R8 overwrite", wordOut, 8'h19);
    ackWord();
    check(wordReady == 1'b0, "R8 final clear", wordReady, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule